// File: doc/BRIEF.md
# Power State Transition Checker

This block watches the supply status of a chip whose power domains can be switched off. Every clock it reads which of three switchable supply sets (numbered 1, 2 and 4) are off, and whether the always-on supply set 3 is running in nominal mode or in turbo mode. From these inputs it names the current system power state. It reports every move into an unnamed supply combination and every move between named states that the transition rules forbid or do not list.

It also keeps one saturating counter for each permitted transition. A simulation or an emulation run can read the counters to see which permitted moves were exercised. The block has no side effects. It can sit next to a power controller and raise a one-cycle error pulse with a cause code that the surrounding checks can log.

Top module: `power_state_checker`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the state output is alloff (code 4), the error pulse is 0, the cause is 0, and every counter is 0.
- R2: The `rail_off` input is decoded as follows: bit 0 set means supply 1 is off, bit 1 set means supply 2 is off, and bit 2 set means supply 4 is off. `core_mode` is 1 for nominal, 2 for turbo, and 0 or 3 for neither. When core_mode is 1 or 2, the state codes are: on = 0 for rail_off 000; var1off = 1 for 001 or 011; var2off = 2 for 010; var4off = 3 for 101; alloff = 4 for 111. Every other combination is undefined, which is code 7.
- R3: The inputs are sampled at a rising edge. The state, error and counter outputs change at that same edge. If the decoded state equals the registered state, no event is raised and no counter moves.
- R4: A move from any other state into the undefined state gives one error pulse with cause 1. Staying in the undefined state raises nothing more.
- R5: A move from alloff to on, or from on to alloff, gives an error pulse with cause 2.
- R6: A move between two named states that is neither permitted nor forbidden gives an error pulse with cause 3.
- R7: The permitted moves raise no error and each advance their own counter. They are, by counter index: 0 on→var1off, 1 on→var2off, 2 var1off→on, 3 var1off→var2off, 4 var1off→var4off, 5 var2off→on, 6 var2off→var1off, 7 var4off→var1off, 8 var4off→alloff, 9 alloff→var4off. Counter i occupies `legal_count[i*CNT_W +: CNT_W]`.
- R8: A counter at 2^CNT_W−1 stays there when its move happens again.
- R9: On leaving the undefined state for a named state, the move is judged from the last named state held before the undefined spell. If that named state is the same as the new one, nothing is raised.
- R10: The error pulse lasts one cycle for each event. The cause output is non-zero exactly while the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rail_off | input | 3 | Off flags of supply sets 1, 2, 4 (bits 0, 1, 2) |
| core_mode | input | 2 | Always-on supply mode: 1 nominal, 2 turbo, else invalid |
| sys_state | output | 3 | Registered system state code |
| err_pulse | output | 1 | One-cycle error flag |
| err_cause | output | 2 | 1 undefined, 2 forbidden, 3 unlisted, 0 none |
| legal_count | output | 10*CNT_W | Per-transition saturating counters, index 0 in the low bits |

## Verification
Every result of this block appears after one register stage. A value driven on `rail_off`/`core_mode` is taken at the next rising edge, and the state, error flag, cause and counters show its effect right after that edge. The bench drives each stimulus on a falling edge and checks on the following falling edge, so each check sees exactly one sampled step. Each named starting state is paired with all 32 input combinations, and a reference model in the bench tracks state, last named state and counters at every step. This covers repeated steps with no change, recovery from an undefined spell and counter saturation.

// File: rtl/pstc_pkg.sv
package pstc_pkg;

    // System state codes; the values are visible on the sys_state port.
    typedef enum logic [2:0] {
        PS_ON     = 3'd0,
        PS_V1OFF  = 3'd1,
        PS_V2OFF  = 3'd2,
        PS_V4OFF  = 3'd3,
        PS_ALLOFF = 3'd4,
        PS_UNDEF  = 3'd7
    } psys_e;

    // Error cause codes.
    typedef enum logic [1:0] {
        CZ_NONE     = 2'd0,
        CZ_UNDEF    = 2'd1,
        CZ_FORBID   = 2'd2,
        CZ_UNLISTED = 2'd3
    } pcause_e;

    localparam logic [1:0] CORE_NOM   = 2'd1;
    localparam logic [1:0] CORE_TURBO = 2'd2;

    typedef struct packed {
        psys_e src;
        psys_e dst;
    } edge_s;

    localparam int NUM_LEGAL  = 10;
    localparam int NUM_FORBID = 2;

    // Permitted moves; the position in this list is the counter index.
    localparam edge_s LEGAL_EDGES [NUM_LEGAL] = '{
        '{PS_ON,     PS_V1OFF},
        '{PS_ON,     PS_V2OFF},
        '{PS_V1OFF,  PS_ON},
        '{PS_V1OFF,  PS_V2OFF},
        '{PS_V1OFF,  PS_V4OFF},
        '{PS_V2OFF,  PS_ON},
        '{PS_V2OFF,  PS_V1OFF},
        '{PS_V4OFF,  PS_V1OFF},
        '{PS_V4OFF,  PS_ALLOFF},
        '{PS_ALLOFF, PS_V4OFF}
    };

    // Moves that are named as forbidden.
    localparam edge_s FORBID_EDGES [NUM_FORBID] = '{
        '{PS_ALLOFF, PS_ON},
        '{PS_ON,     PS_ALLOFF}
    };

endpackage

// File: rtl/pstc_state_decode.sv
module pstc_state_decode
    import pstc_pkg::*;
(
    input  logic [2:0] rail_off_i,
    input  logic [1:0] core_mode_i,
    output psys_e      state_o
);

    logic core_ok;

    always_comb begin
        core_ok = (core_mode_i == CORE_NOM) || (core_mode_i == CORE_TURBO);
        state_o = PS_UNDEF;
        if (core_ok) begin
            // bit0 = supply 1 off, bit1 = supply 2 off, bit2 = supply 4 off
            case (rail_off_i)
                3'b000:          state_o = PS_ON;
                3'b001, 3'b011:  state_o = PS_V1OFF;
                3'b010:          state_o = PS_V2OFF;
                3'b101:          state_o = PS_V4OFF;
                3'b111:          state_o = PS_ALLOFF;
                default:         state_o = PS_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/pstc_edge_rules.sv
module pstc_edge_rules
    import pstc_pkg::*;
(
    input  psys_e                 src_i,
    input  psys_e                 dst_i,
    output logic [NUM_LEGAL-1:0]  legal_hit_o,
    output logic                  forbid_o
);

    logic [NUM_FORBID-1:0] forbid_hit;

    for (genvar gi = 0; gi < NUM_LEGAL; gi++) begin : g_legal
        assign legal_hit_o[gi] = (src_i == LEGAL_EDGES[gi].src) &&
                                 (dst_i == LEGAL_EDGES[gi].dst);
    end

    for (genvar gf = 0; gf < NUM_FORBID; gf++) begin : g_forbid
        assign forbid_hit[gf] = (src_i == FORBID_EDGES[gf].src) &&
                                (dst_i == FORBID_EDGES[gf].dst);
    end

    assign forbid_o = |forbid_hit;

endmodule

// File: rtl/pstc_cov_counters.sv
module pstc_cov_counters #(
    parameter int N = 10,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   inc_i,
    output logic [N*W-1:0] count_o
);

    localparam logic [W-1:0] CMAX = {W{1'b1}};

    typedef struct packed {
        logic [N-1:0][W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int i = 0; i < N; i++) begin
            if (inc_i[i] && (cnt_q.cnt[i] != CMAX)) begin
                cnt_d.cnt[i] = cnt_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.cnt;

    // At most one permitted move can happen per cycle.
    assert_one_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_i));

    for (genvar gc = 0; gc < N; gc++) begin : g_chk
        assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i[gc] && (cnt_q.cnt[gc] != CMAX)) |=>
            (cnt_q.cnt[gc] == W'($past(cnt_q.cnt[gc]) + 1'b1)));
        assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q.cnt[gc] == CMAX) |=> (cnt_q.cnt[gc] == CMAX));
        assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !inc_i[gc] |=> $stable(cnt_q.cnt[gc]));
    end

endmodule

// File: rtl/power_state_checker.sv
module power_state_checker
    import pstc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 rail_off,
    input  logic [1:0]                 core_mode,
    output logic [2:0]                 sys_state,
    output logic                       err_pulse,
    output logic [1:0]                 err_cause,
    output logic [NUM_LEGAL*CNT_W-1:0] legal_count
);

    typedef struct packed {
        psys_e   state;
        psys_e   last_named;
        logic    err;
        pcause_e cause;
    } mon_s;

    mon_s                 mon_d, mon_q;
    psys_e                dec_state;
    psys_e                src_state;
    logic [NUM_LEGAL-1:0] legal_hit;
    logic                 forbid;
    logic [NUM_LEGAL-1:0] inc_vec;

    pstc_state_decode i_decode (
        .rail_off_i  (rail_off),
        .core_mode_i (core_mode),
        .state_o     (dec_state)
    );

    // After an undefined spell, judge the move from the last named state.
    always_comb begin
        src_state = (mon_q.state == PS_UNDEF) ? mon_q.last_named : mon_q.state;
    end

    pstc_edge_rules i_rules (
        .src_i       (src_state),
        .dst_i       (dec_state),
        .legal_hit_o (legal_hit),
        .forbid_o    (forbid)
    );

    always_comb begin
        mon_d       = mon_q;
        mon_d.err   = 1'b0;
        mon_d.cause = CZ_NONE;
        inc_vec     = '0;
        if (dec_state != mon_q.state) begin
            mon_d.state = dec_state;
            if (dec_state == PS_UNDEF) begin
                mon_d.err   = 1'b1;
                mon_d.cause = CZ_UNDEF;
            end else begin
                mon_d.last_named = dec_state;
                if (src_state != dec_state) begin
                    if (|legal_hit) begin
                        inc_vec = legal_hit;
                    end else if (forbid) begin
                        mon_d.err   = 1'b1;
                        mon_d.cause = CZ_FORBID;
                    end else begin
                        mon_d.err   = 1'b1;
                        mon_d.cause = CZ_UNLISTED;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.state      <= PS_ALLOFF;
            mon_q.last_named <= PS_ALLOFF;
            mon_q.err        <= 1'b0;
            mon_q.cause      <= CZ_NONE;
        end else begin
            mon_q <= mon_d;
        end
    end

    pstc_cov_counters #(
        .N (NUM_LEGAL),
        .W (CNT_W)
    ) i_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc_vec),
        .count_o (legal_count)
    );

    assign sys_state = mon_q.state;
    assign err_pulse = mon_q.err;
    assign err_cause = mon_q.cause;

    assert_cause_pairs_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (err_cause != 2'd0));

    assert_event_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (mon_q.state != $past(mon_q.state)));

    assert_undef_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cause == 2'd1) |-> (mon_q.state == PS_UNDEF));

    assert_forbid_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cause == 2'd2) |->
        ((mon_q.state == PS_ON && $past(mon_q.last_named) == PS_ALLOFF) ||
         (mon_q.state == PS_ALLOFF && $past(mon_q.last_named) == PS_ON)));

    assert_named_memory_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.last_named != PS_UNDEF);

endmodule

// File: tb/test_power_state_checker.sv
module test_power_state_checker;

    localparam int CW   = 8;
    localparam int NL   = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [2:0]       rail_off;
    logic [1:0]       core_mode;
    logic [2:0]       sys_state;
    logic             err_pulse;
    logic [1:0]       err_cause;
    logic [NL*CW-1:0] legal_count;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    // reference model
    int mstate, mlast, mcause;
    int mcnt [NL];

    always #10 clk = ~clk;

    power_state_checker #(.CNT_W(CW)) i_power_state_checker (
        .clk(clk), .rst_n(rst_n), .rail_off(rail_off), .core_mode(core_mode),
        .sys_state(sys_state), .err_pulse(err_pulse), .err_cause(err_cause),
        .legal_count(legal_count)
    );

    function automatic int ref_decode(input int r, input int c);
        if (c != 1 && c != 2) return 7;
        if (r == 0) return 0;
        if (r == 1 || r == 3) return 1;
        if (r == 2) return 2;
        if (r == 5) return 3;
        if (r == 7) return 4;
        return 7;
    endfunction

    function automatic int ref_legal_idx(input int s, input int d);
        int key = s * 8 + d;
        case (key)
            1:  return 0;   // on -> var1off
            2:  return 1;   // on -> var2off
            8:  return 2;   // var1off -> on
            10: return 3;   // var1off -> var2off
            11: return 4;   // var1off -> var4off
            16: return 5;   // var2off -> on
            17: return 6;   // var2off -> var1off
            25: return 7;   // var4off -> var1off
            28: return 8;   // var4off -> alloff
            35: return 9;   // alloff -> var4off
            default: return -1;
        endcase
    endfunction

    function automatic int rails_of(input int s);
        case (s)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 5;
            default: return 7;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Update the model for one sampled input and return the expected cause.
    task automatic model_step(input int r, input int c);
        int d, src, idx;
        d = ref_decode(r, c);
        mcause = 0;
        if (d != mstate) begin
            if (d == 7) begin
                mcause = 1;
            end else begin
                src = (mstate == 7) ? mlast : mstate;
                mlast = d;
                if (src != d) begin
                    idx = ref_legal_idx(src, d);
                    if (idx >= 0) begin
                        if (mcnt[idx] < CMAX) mcnt[idx]++;
                    end else if ((src == 4 && d == 0) || (src == 0 && d == 4)) begin
                        mcause = 2;
                    end else begin
                        mcause = 3;
                    end
                end
            end
            mstate = d;
        end
    endtask

    function automatic string cause_req(input int c);
        case (c)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Called at a falling edge; drives, waits one cycle, checks.
    task automatic step(input int r, input int c);
        rail_off  = r[2:0];
        core_mode = c[1:0];
        model_step(r, c);
        @(negedge clk);
        chk(sys_state == mstate[2:0], "R2", "state", sys_state, mstate);
        chk(err_pulse == (mcause != 0), cause_req(mcause), "err_pulse", err_pulse, mcause != 0);
        chk(err_cause == mcause[1:0], cause_req(mcause), "err_cause", err_cause, mcause);
    endtask

    task automatic check_counters(input string req);
        for (int i = 0; i < NL; i++) begin
            chk(legal_count[i*CW +: CW] == mcnt[i][CW-1:0], req, "counter",
                legal_count[i*CW +: CW], mcnt[i]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        rail_off  = 3'b111;
        core_mode = 2'd1;
        mstate = 4; mlast = 4; mcause = 0;
        for (int i = 0; i < NL; i++) mcnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1: values under reset
        chk(sys_state == 3'd4, "R1", "state in reset", sys_state, 4);
        chk(err_pulse == 1'b0, "R1", "err in reset", err_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sys_state == 3'd4, "R1", "state after reset", sys_state, 4);
        chk(err_pulse == 1'b0, "R1", "err after reset", err_pulse, 0);
        chk(err_cause == 2'd0, "R1", "cause after reset", err_cause, 0);
        check_counters("R1");

        // R3: holding the same inputs raises nothing
        step(7, 1);
        step(7, 2);

        // Exhaustive: every named start state against all 32 input codes
        for (int s = 0; s < 5; s++) begin
            for (int code = 0; code < 32; code++) begin
                step(rails_of(s), 1);
                step(code & 7, code >> 3);
                step(code & 7, code >> 3);   // R3: repeated input, no new event
            end
        end
        check_counters("R7");

        // R9: undefined spell returning to the same named state
        step(0, 1);
        step(4, 1);
        step(6, 2);
        step(0, 2);
        chk(err_pulse == 1'b0, "R9", "return to same state", err_pulse, 0);
        // R9: undefined spell from on, then alloff -> forbidden from on
        step(4, 0);
        step(7, 1);
        chk(err_cause == 2'd2, "R9", "judged from last named", err_cause, 2);

        // R8: saturate on<->var1off counters
        step(0, 1);
        for (int k = 0; k < 300; k++) begin
            step(1, 1);
            step(0, 2);
        end
        chk(legal_count[0 +: CW] == CMAX[CW-1:0], "R8", "counter 0 saturated",
            legal_count[0 +: CW], CMAX);
        chk(legal_count[2*CW +: CW] == CMAX[CW-1:0], "R8", "counter 2 saturated",
            legal_count[2*CW +: CW], CMAX);
        check_counters("R8");

        // R10: pulse is one cycle long while inputs stay put
        step(4, 1);
        step(4, 1);
        chk(err_pulse == 1'b0 && err_cause == 2'd0, "R10", "pulse dropped",
            err_cause, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule